// File: doc/BRIEF.md
# Adaptive Transmit Probability Controller

This block decides, packet by packet, whether a packet about to be enqueued is admitted or discarded. The decision is driven by rate targets, not by queue-depth thresholds. Each traffic pipe has a configured floor rate, a ceiling rate and a strict priority level, where level 0 is the most important. The block counts the bytes each pipe offers during a fixed period. At the end of each period it retunes an allocated rate per pipe from a single feedback bit that says whether spare bandwidth exists. It then turns the allocation into an admission probability, which is the allocation divided by the measured offered rate.

On enqueue, the upper bits of a header-derived key select the pipe. The pipe's stored probability is compared with a pseudo-random sample, and the verdict comes out one clock later. After each period tick the update engine rewrites the table one pipe per clock. Lookups continue every cycle while it does so. Every table write is also reported on an update stream, so that a neighbouring scheduler or monitor can follow the allocations.

`NPIPE` must be a power of two. All rates are 16-bit byte counts per period. Probabilities are 16-bit unsigned fractions, where 16'hFFFF stands for certain admission.

Top module: `tpc_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `upd_valid` and `dec_valid` are 0. After reset every pipe has allocation 0 and probability 16'hFFFF.
- R2: A tick occurs once every `PERIOD` clocks. The first tick is `PERIOD` clocks after reset. In the clocks after a tick, `upd_valid` is high for `NPIPE` consecutive cycles, with `upd_pipe` stepping 0, 1, ..., `NPIPE`-1. Each cycle carries that pipe's new allocation and probability.
- R3: The feedback bit used at a tick is 1 when `occ` < `LOW_MARK` and `occ` is not greater than the value `occ` had at the previous tick. At the first tick, that previous value counts as all ones.
- R4: With feedback 1, a pipe whose allocation is below its ceiling gets min(allocation + `STEP`, ceiling). A pipe at or above its ceiling is unchanged.
- R5: With feedback 0, only pipes whose allocation exceeds their floor are candidates. Of those, only the ones with the numerically largest priority value shrink. A shrinking pipe loses max(allocation >> `DEC_SHIFT`, 1), but never drops below its floor. All other pipes are unchanged.
- R6: The offered rate of a pipe is the sum of `enq_len` over its enqueue requests in one period, admitted or not. The sum saturates at 65535 and is cleared at each tick. A request made in the tick cycle counts toward the next period.
- R7: The probability written for a pipe is 16'hFFFF when its new allocation is at least its measured offered rate. Otherwise it is floor(allocation × 65536 / offered).
- R8: The pipe of a request is `enq_key[KEY_W-1 -: log2(NPIPE)]`. The clock after each request, `dec_valid` is 1 and `dec_pipe` holds that pipe. Requests are served every cycle, including during a table sweep.
- R9: A pipe whose probability is 16'hFFFF admits every request. A pipe whose probability is 0 drops every request.
- R10: For any other probability, a request is admitted when a free-running 16-bit LFSR sample is strictly below the probability. The long-run admission ratio therefore follows the probability.
- R11: Four pipes share a 100-byte-per-period output. Their floors are 10, 20, 0, 0, their ceilings 30, 40, 100, 100, their priorities 0 to 3, and their offered loads 15, 50, 15, 100. Under this load, the probabilities settle to 1, 0.8, 1 and about 0.3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_min | input | NPIPE*16 | Per-pipe floor rate, pipe i at bits [16i+15:16i] |
| cfg_max | input | NPIPE*16 | Per-pipe ceiling rate |
| cfg_prio | input | NPIPE*PRIO_W | Per-pipe strict priority, 0 most important |
| occ | input | OCC_W | Shared queue occupancy |
| enq_valid | input | 1 | Enqueue request |
| enq_key | input | KEY_W | Header-derived class key |
| enq_len | input | LEN_W | Packet length in bytes |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | 1 = admit, 0 = drop |
| dec_pipe | output | log2(NPIPE) | Pipe of the verdict |
| upd_valid | output | 1 | Table write report valid |
| upd_pipe | output | log2(NPIPE) | Pipe being rewritten |
| upd_alloc | output | 16 | New allocated rate |
| upd_prob | output | 16 | New admission probability |

## Verification
The hardest state to reach from the ports is a steady operating point where several pipes sit at their ceilings while the lowest-priority pipe oscillates around the leftover capacity. Only a closed loop produces it. The bench closes that loop itself. Before each tick it raises or lowers `occ` according to whether the admitted load implied by the current allocations exceeds the output capacity, and it runs this for over a hundred periods. Saturation of the byte meter and a pipe stuck at probability zero are reached by directed windows: seventeen maximum-length packets in one period, and a pipe that offers traffic before any spare bandwidth has ever been signalled.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    localparam int RATE_W = 16;
    localparam int PROB_W = 16;

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [PROB_W-1:0] prob_t;

    localparam prob_t PROB_ONE = '1;

    typedef struct packed {
        rate_t alloc;
        prob_t prob;
    } entry_t;

    // admission fraction from allocation and measured offer
    function automatic prob_t prob_of(rate_t alloc, rate_t offered);
        logic [RATE_W+PROB_W-1:0] q;
        if (alloc >= offered) return PROB_ONE;
        q = {alloc, {PROB_W{1'b0}}} / {{PROB_W{1'b0}}, offered};
        return q[PROB_W-1:0];
    endfunction

    function automatic rate_t sat_add(rate_t a, rate_t b);
        logic [RATE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[RATE_W] ? '1 : s[RATE_W-1:0];
    endfunction

    // linear raise toward the ceiling
    function automatic rate_t rate_up(rate_t a, rate_t ceil_r, rate_t step);
        rate_t s;
        if (a >= ceil_r) return a;
        s = sat_add(a, step);
        return (s > ceil_r) ? ceil_r : s;
    endfunction

    // geometric cut toward the floor
    function automatic rate_t rate_down(rate_t a, rate_t floor_r, int shift);
        rate_t d;
        d = a >> shift;
        if (d == '0) d = rate_t'(1);
        if (a <= floor_r) return a;
        if (d >= (a - floor_r)) return floor_r;
        return a - d;
    endfunction

endpackage

// File: rtl/tpc_lfsr.sv
module tpc_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] sample
);
    logic [15:0] st;
    logic        fb;

    assign fb     = st[15] ^ st[13] ^ st[12] ^ st[10];
    assign sample = st;

    always_ff @(posedge clk) begin
        if (rst) st <= SEED;
        else     st <= {st[14:0], fb};
    end
endmodule

// File: rtl/tpc_meter.sv
module tpc_meter
    import tpc_pkg::*;
#(
    parameter int NPIPE  = 4,
    parameter int LEN_W  = 12,
    parameter int PIPE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hit_valid,
    input  logic [PIPE_W-1:0] hit_pipe,
    input  logic [LEN_W-1:0]  hit_len,
    output rate_t             meas [NPIPE]
);
    rate_t run [NPIPE];
    rate_t len_r;

    assign len_r = rate_t'(hit_len);

    for (genvar g = 0; g < NPIPE; g++) begin : g_ctr
        logic mine;
        assign mine = hit_valid && (hit_pipe == PIPE_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                run[g]  <= '0;
                meas[g] <= '0;
            end else if (tick) begin
                meas[g] <= run[g];
                run[g]  <= mine ? len_r : '0;
            end else if (mine) begin
                run[g]  <= sat_add(run[g], len_r);
            end
        end
    end
endmodule

// File: rtl/tpc_update.sv
module tpc_update
    import tpc_pkg::*;
#(
    parameter int NPIPE     = 4,
    parameter int PIPE_W    = 2,
    parameter int PRIO_W    = 2,
    parameter int OCC_W     = 12,
    parameter int PERIOD    = 4000,
    parameter int STEP      = 2,
    parameter int DEC_SHIFT = 3,
    parameter int LOW_MARK  = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPIPE*RATE_W-1:0]   cfg_min,
    input  logic [NPIPE*RATE_W-1:0]   cfg_max,
    input  logic [NPIPE*PRIO_W-1:0]   cfg_prio,
    input  logic [OCC_W-1:0]          occ,
    input  rate_t                     meas [NPIPE],
    output logic                      tick,
    output prob_t                     tab_prob [NPIPE],
    output logic                      upd_valid,
    output logic [PIPE_W-1:0]         upd_pipe,
    output entry_t                    upd_entry
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
    localparam logic [PIPE_W-1:0] TOP = PIPE_W'(NPIPE - 1);

    rate_t              lo   [NPIPE];
    rate_t              hi   [NPIPE];
    logic [PRIO_W-1:0]  lvl  [NPIPE];
    rate_t              alloc[NPIPE];

    for (genvar g = 0; g < NPIPE; g++) begin : g_cfg
        assign lo[g]  = cfg_min[g*RATE_W +: RATE_W];
        assign hi[g]  = cfg_max[g*RATE_W +: RATE_W];
        assign lvl[g] = cfg_prio[g*PRIO_W +: PRIO_W];
    end

    logic [CNT_W-1:0]  cnt;
    logic [OCC_W-1:0]  prev_occ;
    logic              busy;
    logic [PIPE_W-1:0] idx;
    logic              spare_l;
    logic              vic_any_l;
    logic [PRIO_W-1:0] vic_lvl_l;

    assign tick = (cnt == LAST);

    // feedback bit: queue low and not growing since last tick
    logic spare;
    assign spare = (occ < OCC_W'(LOW_MARK)) && (occ <= prev_occ);

    // lowest-priority level that still holds bandwidth above its floor
    logic              vic_any;
    logic [PRIO_W-1:0] vic_lvl;
    always_comb begin
        vic_any = 1'b0;
        vic_lvl = '0;
        for (int i = 0; i < NPIPE; i++) begin
            if (alloc[i] > lo[i] && (!vic_any || lvl[i] > vic_lvl)) begin
                vic_any = 1'b1;
                vic_lvl = lvl[i];
            end
        end
    end

    rate_t nxt;
    always_comb begin
        if (spare_l)
            nxt = rate_up(alloc[idx], hi[idx], rate_t'(STEP));
        else if (vic_any_l && lvl[idx] == vic_lvl_l)
            nxt = rate_down(alloc[idx], lo[idx], DEC_SHIFT);
        else
            nxt = alloc[idx];
    end

    prob_t nxt_p;
    assign nxt_p = prob_of(nxt, meas[idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            prev_occ  <= '1;
            busy      <= 1'b0;
            idx       <= '0;
            spare_l   <= 1'b0;
            vic_any_l <= 1'b0;
            vic_lvl_l <= '0;
            upd_valid <= 1'b0;
            upd_pipe  <= '0;
            upd_entry <= '0;
            for (int i = 0; i < NPIPE; i++) begin
                alloc[i]    <= '0;
                tab_prob[i] <= PROB_ONE;
            end
        end else begin
            upd_valid <= 1'b0;
            cnt       <= tick ? '0 : cnt + 1'b1;
            if (tick) begin
                busy      <= 1'b1;
                idx       <= '0;
                spare_l   <= spare;
                vic_any_l <= vic_any;
                vic_lvl_l <= vic_lvl;
                prev_occ  <= occ;
            end else if (busy) begin
                alloc[idx]      <= nxt;
                tab_prob[idx]   <= nxt_p;
                upd_valid       <= 1'b1;
                upd_pipe        <= idx;
                upd_entry.alloc <= nxt;
                upd_entry.prob  <= nxt_p;
                if (idx == TOP) busy <= 1'b0;
                else            idx  <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpc_decide.sv
module tpc_decide
    import tpc_pkg::*;
#(
    parameter int NPIPE  = 4,
    parameter int PIPE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PIPE_W-1:0] req_pipe,
    input  prob_t             tab_prob [NPIPE],
    input  prob_t             rnd,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [PIPE_W-1:0] dec_pipe
);
    prob_t p;
    logic  pass;

    assign p    = tab_prob[req_pipe];
    assign pass = (p == PROB_ONE) || (rnd < p);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_pipe   <= '0;
        end else begin
            dec_valid  <= req_valid;
            dec_accept <= req_valid && pass;
            if (req_valid) dec_pipe <= req_pipe;
        end
    end
endmodule

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
    import tpc_pkg::*;
#(
    parameter int NPIPE     = 4,
    parameter int PRIO_W    = 2,
    parameter int KEY_W     = 6,
    parameter int LEN_W     = 12,
    parameter int OCC_W     = 12,
    parameter int PERIOD    = 4000,
    parameter int STEP      = 2,
    parameter int DEC_SHIFT = 3,
    parameter int LOW_MARK  = 64,
    localparam int PIPE_W   = (NPIPE > 1) ? $clog2(NPIPE) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPIPE*RATE_W-1:0]  cfg_min,
    input  logic [NPIPE*RATE_W-1:0]  cfg_max,
    input  logic [NPIPE*PRIO_W-1:0]  cfg_prio,
    input  logic [OCC_W-1:0]         occ,
    input  logic                     enq_valid,
    input  logic [KEY_W-1:0]         enq_key,
    input  logic [LEN_W-1:0]         enq_len,
    output logic                     dec_valid,
    output logic                     dec_accept,
    output logic [PIPE_W-1:0]        dec_pipe,
    output logic                     upd_valid,
    output logic [PIPE_W-1:0]        upd_pipe,
    output logic [RATE_W-1:0]        upd_alloc,
    output logic [PROB_W-1:0]        upd_prob
);
    logic              tick;
    logic [PIPE_W-1:0] key_pipe;
    rate_t             meas     [NPIPE];
    prob_t             tab_prob [NPIPE];
    prob_t             rnd;
    entry_t            upd_entry;

    assign key_pipe  = enq_key[KEY_W-1 -: PIPE_W];
    assign upd_alloc = upd_entry.alloc;
    assign upd_prob  = upd_entry.prob;

    tpc_lfsr u_rng (
        .clk    (clk),
        .rst    (rst),
        .sample (rnd)
    );

    tpc_meter #(.NPIPE(NPIPE), .LEN_W(LEN_W), .PIPE_W(PIPE_W)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hit_valid (enq_valid),
        .hit_pipe  (key_pipe),
        .hit_len   (enq_len),
        .meas      (meas)
    );

    tpc_update #(
        .NPIPE(NPIPE), .PIPE_W(PIPE_W), .PRIO_W(PRIO_W), .OCC_W(OCC_W),
        .PERIOD(PERIOD), .STEP(STEP), .DEC_SHIFT(DEC_SHIFT), .LOW_MARK(LOW_MARK)
    ) u_upd (
        .clk       (clk),
        .rst       (rst),
        .cfg_min   (cfg_min),
        .cfg_max   (cfg_max),
        .cfg_prio  (cfg_prio),
        .occ       (occ),
        .meas      (meas),
        .tick      (tick),
        .tab_prob  (tab_prob),
        .upd_valid (upd_valid),
        .upd_pipe  (upd_pipe),
        .upd_entry (upd_entry)
    );

    tpc_decide #(.NPIPE(NPIPE), .PIPE_W(PIPE_W)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (enq_valid),
        .req_pipe   (key_pipe),
        .tab_prob   (tab_prob),
        .rnd        (rnd),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_pipe   (dec_pipe)
    );
endmodule

// File: rtl/tpc_ctrl_chk.sv
module tpc_ctrl_chk
    import tpc_pkg::*;
#(
    parameter int NPIPE  = 4,
    parameter int PIPE_W = 2,
    parameter int KEY_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPIPE*RATE_W-1:0] cfg_max,
    input  logic                    enq_valid,
    input  logic [KEY_W-1:0]        enq_key,
    input  logic                    dec_valid,
    input  logic                    dec_accept,
    input  logic [PIPE_W-1:0]       dec_pipe,
    input  logic                    upd_valid,
    input  logic [PIPE_W-1:0]       upd_pipe,
    input  logic [RATE_W-1:0]       upd_alloc,
    input  prob_t                   tab_prob [NPIPE]
);
    logic [PIPE_W-1:0] kp;
    prob_t             kprob;
    rate_t             cap;

    assign kp    = enq_key[KEY_W-1 -: PIPE_W];
    assign kprob = tab_prob[kp];
    assign cap   = cfg_max[upd_pipe*RATE_W +: RATE_W];

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!upd_valid && !dec_valid));

    a_r2_sweep_starts_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(upd_valid) |-> (upd_pipe == '0));

    a_r2_sweep_steps: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_pipe != PIPE_W'(NPIPE - 1)) |=>
            (upd_valid && upd_pipe == $past(upd_pipe) + 1'b1));

    a_r4_within_ceiling: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (upd_alloc <= cap));

    a_r8_verdict_follows: assert property (@(posedge clk) disable iff (rst)
        enq_valid |=> (dec_valid && dec_pipe == $past(kp)));

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !enq_valid |=> !dec_valid);

    a_r9_full_admits: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && kprob == PROB_ONE) |=> dec_accept);

    a_r9_zero_drops: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && kprob == '0) |=> !dec_accept);
endmodule

bind tpc_ctrl tpc_ctrl_chk #(.NPIPE(NPIPE), .PIPE_W(PIPE_W), .KEY_W(KEY_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_max    (cfg_max),
    .enq_valid  (enq_valid),
    .enq_key    (enq_key),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_pipe   (dec_pipe),
    .upd_valid  (upd_valid),
    .upd_pipe   (upd_pipe),
    .upd_alloc  (upd_alloc),
    .tab_prob   (tab_prob)
);

// File: tb/sim_tpc_ctrl.sv
module sim_tpc_ctrl;
    localparam int NP  = 4;
    localparam int PW  = 2;
    localparam int KW  = 6;
    localparam int LW  = 12;
    localparam int OW  = 12;
    localparam int PER = 512;
    localparam int STP = 2;
    localparam int SH  = 3;
    localparam int LOW = 64;

    logic              clk = 0;
    logic              rst = 1;
    logic [NP*16-1:0]  cfg_min, cfg_max;
    logic [NP*PW-1:0]  cfg_prio;
    logic [OW-1:0]     occ = '0;
    logic              enq_valid = 0;
    logic [KW-1:0]     enq_key = '0;
    logic [LW-1:0]     enq_len = '0;
    logic              dec_valid, dec_accept;
    logic [1:0]        dec_pipe;
    logic              upd_valid;
    logic [1:0]        upd_pipe;
    logic [15:0]       upd_alloc, upd_prob;

    int mn [NP], mx [NP], pr [NP];
    int ea [NP], ep [NP], sum [NP];
    int prev_occ;
    int total = 0, bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            cfg_min[i*16 +: 16]  = 16'(mn[i]);
            cfg_max[i*16 +: 16]  = 16'(mx[i]);
            cfg_prio[i*PW +: PW] = PW'(pr[i]);
        end
    end

    tpc_ctrl #(.NPIPE(NP), .PRIO_W(PW), .KEY_W(KW), .LEN_W(LW), .OCC_W(OW),
               .PERIOD(PER), .STEP(STP), .DEC_SHIFT(SH), .LOW_MARK(LOW)) u0 (
        .clk(clk), .rst(rst), .cfg_min(cfg_min), .cfg_max(cfg_max), .cfg_prio(cfg_prio),
        .occ(occ), .enq_valid(enq_valid), .enq_key(enq_key), .enq_len(enq_len),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_pipe(dec_pipe),
        .upd_valid(upd_valid), .upd_pipe(upd_pipe), .upd_alloc(upd_alloc), .upd_prob(upd_prob));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_prob(int a, int m);
        if (a >= m) return 65535;
        return int'((longint'(a) * 65536) / m);
    endfunction

    function automatic int m_up(int a, int c);
        if (a >= c) return a;
        return (a + STP > c) ? c : a + STP;
    endfunction

    function automatic int m_down(int a, int f);
        int d;
        d = a >> SH;
        if (d == 0) d = 1;
        if (a <= f) return a;
        if (d >= a - f) return f;
        return a - d;
    endfunction

    task automatic do_reset();
        rst = 1;
        enq_valid = 0;
        repeat (3) @(negedge clk);
        check(!upd_valid && !dec_valid, "R1 idle in reset", {upd_valid, dec_valid}, 0);
        for (int i = 0; i < NP; i++) begin ea[i] = 0; ep[i] = 65535; sum[i] = 0; end
        prev_occ = 32'hFFFF_FFFF;
        rst = 0;
        @(negedge clk);
        check(!upd_valid && !dec_valid, "R1 idle after reset", {upd_valid, dec_valid}, 0);
    endtask

    // one request; verdict sampled at next falling edge
    task automatic send(input int p, input int len, output bit acc);
        enq_valid = 1;
        enq_key   = {2'(p), 4'($urandom % 16)};
        enq_len   = LW'(len);
        @(negedge clk);
        enq_valid = 0;
        check(dec_valid && dec_pipe == 2'(p), "R8 verdict pipe", dec_pipe, p);
        if (ep[p] == 65535) check(dec_accept, "R9 full admits", dec_accept, 1);
        if (ep[p] == 0)     check(!dec_accept, "R9 zero drops", dec_accept, 0);
        acc = dec_accept;
        sum[p] = (sum[p] + len > 65535) ? 65535 : sum[p] + len;
    endtask

    // hold occ through the tick, then check every table write
    task automatic close_period(input int o);
        bit spare, vany;
        int vl, wait_n, na;
        occ = OW'(o);
        wait_n = 0;
        while (!upd_valid && wait_n < PER + 20) begin @(negedge clk); wait_n++; end
        check(upd_valid, "R2 sweep seen", upd_valid, 1);
        spare = (o < LOW) && (longint'(o) <= longint'(unsigned'(prev_occ)));
        prev_occ = o;
        vany = 0; vl = 0;
        for (int i = 0; i < NP; i++)
            if (ea[i] > mn[i] && (!vany || pr[i] > vl)) begin vany = 1; vl = pr[i]; end
        for (int i = 0; i < NP; i++) begin
            if (spare)                   na = m_up(ea[i], mx[i]);           // R4
            else if (vany && pr[i] == vl) na = m_down(ea[i], mn[i]);        // R5
            else                         na = ea[i];
            ea[i] = na;
            ep[i] = m_prob(na, sum[i]);                                    // R7
            check(upd_valid && upd_pipe == 2'(i), "R2 sweep order", upd_pipe, i);
            check(upd_alloc == 16'(na), spare ? "R3 R4 alloc" : "R3 R5 alloc", upd_alloc, na);
            check(upd_prob == 16'(ep[i]), "R6 R7 prob", upd_prob, ep[i]);
            if (i < NP - 1) @(negedge clk);
        end
        for (int i = 0; i < NP; i++) sum[i] = 0;
        @(negedge clk);
    endtask

    initial begin
        while (cycles < 190000) begin @(posedge clk); cycles++; end
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit a;
        int acc_n;
        void'($urandom(32'h5EED));

        // directed corners
        mn = '{10, 20, 0, 0}; mx = '{30, 40, 100, 100}; pr = '{0, 1, 2, 3};
        do_reset();
        for (int i = 0; i < NP; i++) send(i, 0, a);      // R1: all admit
        send(0, 40, a);
        close_period(200);                               // no spare, allocations stay 0 -> R1
        for (int k = 0; k < 6; k++) send(0, 0, a);       // R9 pipe 0 now at prob 0
        send(1, 0, a);
        close_period(200);
        for (int k = 0; k < 17; k++) send(2, 4095, a);   // R6 saturation
        close_period(0);                                 // R3 spare, R4 raise

        // closed-loop convergence
        do_reset();
        for (int t = 0; t < 120; t++) begin
            int eff;
            int off [NP];
            off = '{15, 50, 15, 100};
            eff = 0;
            for (int i = 0; i < NP; i++) begin
                send(i, off[i], a);
                eff += (ea[i] < off[i]) ? ea[i] : off[i];
            end
            if (t == 119) begin
                acc_n = 0;
                for (int k = 0; k < 200; k++) begin send(1, 0, a); acc_n += int'(a); end
                check(acc_n >= 120 && acc_n <= 195, "R10 admit ratio", acc_n, 160);
            end
            close_period(eff > 100 ? 500 : 0);
        end
        check(ep[0] == 65535 && upd_valid == 0, "R11 pipe0 prob", ep[0], 65535);
        check(ep[1] == 52428, "R11 pipe1 prob", ep[1], 52428);
        check(ep[2] == 65535, "R11 pipe2 prob", ep[2], 65535);
        check(ep[3] >= 16384 && ep[3] <= 22937, "R11 pipe3 prob", ep[3], 19660);

        // constrained random
        rst = 1;
        for (int i = 0; i < NP; i++) begin
            mn[i] = $urandom % 60;
            mx[i] = mn[i] + $urandom % 300;
            pr[i] = $urandom % 4;
        end
        do_reset();
        for (int t = 0; t < 60; t++) begin
            int n, o;
            n = $urandom % 9;
            for (int k = 0; k < n; k++) send($urandom % NP, $urandom % 600, a);
            case ($urandom % 4)
                0: o = (prev_occ > 4095 || prev_occ < 0) ? 10 : prev_occ;
                1: o = $urandom % LOW;
                2: o = LOW + $urandom % 2000;
                default: o = $urandom % (LOW + 8);
            endcase
            close_period(o);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule